// File: doc/BRIEF.md
# 8-Bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. A decoder outside the block presents two operands, an operation code and, for single-flag operations, a 3-bit flag index. The result appears combinationally on the same cycle. The 8-bit status register is written at the next rising clock edge, and only when the operation is marked valid.

Every operation carries its own mask of the flags it may change. Flags outside that mask keep their previous value. The carry used by add-with-carry, subtract-with-carry, compare-with-carry and the rotates is the C bit held in the status register. The zero test for the carry-chained subtract and compare also reads the held Z bit. This lets a wider comparison be built from a chain of 8-bit steps.

Top module: `alu8_status_core`

## Requirements
- R1: After reset the status register reads 0x00.
- R2: Status bits from bit 7 to bit 0 are I, T, H, S, V, N, Z, C. The register changes only on a clock edge where `op_valid` is 1. Otherwise it holds, whatever the other inputs are.
- R3: ADD (op 0) and ADC (op 1) give a+b, and a+b+C for ADC. They update Z, C, N, V, S and H. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R4: SUB (op 2), CP (op 4) and NEG (op 10) give a-b, a-b and 0-a. They update Z, C, N, V, S and H, with C the borrow out of bit 7 and H the borrow out of bit 3. CP drives the same result and flags as SUB.
- R5: SBC (op 3) and CPC (op 5) give a-b-C with the same flag rules as R4, except that Z becomes 1 only when the result is zero and Z was already 1.
- R6: AND (op 6), OR (op 7) and XOR (op 8) clear V, update Z, N and S, and leave C and H unchanged.
- R7: INC (op 11) and DEC (op 12) update Z, N, V and S and leave C and H unchanged. V is 1 when INC gives 0x80 or DEC gives 0x7F.
- R8: COM (op 9) gives 0xFF-a, sets C, clears V, updates Z, N and S, and leaves H unchanged. NEG sets C exactly when its result is nonzero and sets V exactly when its result is 0x80.
- R9: LSR (op 13) loads 0 into bit 7, ASR (op 14) keeps bit 7, and ROR (op 15) loads C into bit 7. All three move bit 0 into C, set V to N XOR C after the shift, update Z, N and S, and leave H unchanged.
- R10: LSL (op 16) loads 0 into bit 0 and ROL (op 17) loads C into bit 0. Both move bit 7 into C, set H from operand bit 3, set V to N XOR C, and update Z, N and S.
- R11: SWAP (op 18) exchanges bits 3:0 with bits 7:4 and changes no flag.
- R12: FSET (op 19) sets and FCLR (op 20) clears the single status bit chosen by `bit_sel`. All other status bits are unchanged.
- R13: Every operation that updates S leaves S equal to N XOR V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Commit flags of the present operation at the next edge |
| op | input | 5 | Operation code |
| opd_a | input | 8 | First operand (the only one for unary operations) |
| opd_b | input | 8 | Second operand |
| bit_sel | input | 3 | Status bit index for FSET/FCLR |
| result | output | 8 | Combinational operation result |
| status | output | 8 | Registered status flags I,T,H,S,V,N,Z,C |

## Verification
The bench targets the boundary values where flag rules diverge:
- 0x7F+1 and 0x80-1, where signed overflow appears. A design that takes V from the carry would miss these.
- A borrow out of bit 3 alone, which catches an H computed on the wrong nibble or with the wrong polarity.
- Chained subtract-with-carry on a zero result, both with and without a prior Z. A design without the sticky rule would report equality for a wide value that is not zero.
- INC, DEC, the logic operations and SWAP run on a status with C and H preset. This exposes a mask that clobbers flags the operation must leave alone.
- Shifts and rotates with C preset. A rotate that drops the carry, or a V taken before the shift, gives a wrong bit 7 or bit 0 or a wrong V.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;
    localparam int SRW = 8;
    localparam int SELW = $clog2(SRW);

    // status bit positions (order is architectural)
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;
    localparam int FT = 6;
    localparam int FI = 7;

    localparam logic [SRW-1:0] M_FULL  = SRW'((1 << FH) | (1 << FS) | (1 << FV) | (1 << FN) | (1 << FZ) | (1 << FC));
    localparam logic [SRW-1:0] M_LOGIC = SRW'((1 << FS) | (1 << FV) | (1 << FN) | (1 << FZ));
    localparam logic [SRW-1:0] M_NOH   = SRW'((1 << FS) | (1 << FV) | (1 << FN) | (1 << FZ) | (1 << FC));

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ASR  = 5'd14,
        OP_ROR  = 5'd15,
        OP_LSL  = 5'd16,
        OP_ROL  = 5'd17,
        OP_SWAP = 5'd18,
        OP_FSET = 5'd19,
        OP_FCLR = 5'd20
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0]  res;
        logic [SRW-1:0] flags;
        logic [SRW-1:0] mask;
    } alu_calc_t;

    typedef struct packed {
        logic [SRW-1:0] status;
    } alu_regs_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out
);
    localparam int NW = DW / 2;

    logic [DW:0] full_w;
    logic [NW:0] low_w;

    always_comb begin
        if (sub) begin
            full_w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            low_w  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            full_w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            low_w  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end
        res   = full_w[DW-1:0];
        c_out = full_w[DW];
        h_out = low_w[NW];
        if (sub)
            v_out = (a[DW-1] != b[DW-1]) && (res[DW-1] != a[DW-1]);
        else
            v_out = (a[DW-1] == b[DW-1]) && (res[DW-1] != a[DW-1]);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out
);
    localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

    always_comb begin
        res   = a;
        c_out = 1'b0;
        h_out = 1'b0;
        v_out = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_COM: begin
                res   = ~a;
                c_out = 1'b1;
            end
            OP_INC: begin
                res   = a + 1'b1;
                v_out = (res == MIN_NEG);
            end
            OP_DEC: begin
                res   = a - 1'b1;
                v_out = (res == MAX_POS);
            end
            OP_LSR, OP_ASR, OP_ROR: begin
                c_out = a[0];
                if (op == OP_LSR)
                    res = {1'b0, a[DW-1:1]};
                else if (op == OP_ASR)
                    res = {a[DW-1], a[DW-1:1]};
                else
                    res = {cin, a[DW-1:1]};
                v_out = res[DW-1] ^ c_out;
            end
            OP_LSL, OP_ROL: begin
                c_out = a[DW-1];
                h_out = a[NW-1];
                res   = (op == OP_ROL) ? {a[DW-2:0], cin} : {a[DW-2:0], 1'b0};
                v_out = res[DW-1] ^ c_out;
            end
            OP_SWAP: res = {a[NW-1:0], a[DW-1:NW]};
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_flag_merge.sv
module alu8_flag_merge #(
    parameter int SRW = 8
) (
    input  logic [SRW-1:0] cur,
    input  logic           upd,
    input  logic [SRW-1:0] mask,
    input  logic [SRW-1:0] newf,
    output logic [SRW-1:0] nxt
);
    for (genvar i = 0; i < SRW; i++) begin : g_bit
        assign nxt[i] = (upd && mask[i]) ? newf[i] : cur[i];
    end

endmodule

// File: rtl/alu8_status_core.sv
module alu8_status_core
    import alu8_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OPW-1:0]  op,
    input  logic [DW-1:0]   opd_a,
    input  logic [DW-1:0]   opd_b,
    input  logic [SELW-1:0] bit_sel,
    output logic [DW-1:0]   result,
    output logic [SRW-1:0]  status
);
    alu_op_e   op_e;
    alu_regs_t st_d, st_q;
    alu_calc_t calc;

    logic [DW-1:0] as_a, as_b, as_res;
    logic          as_cin, as_sub, as_c, as_h, as_v;
    logic [DW-1:0] bo_res;
    logic          bo_c, bo_h, bo_v;
    logic [SRW-1:0] merged;

    logic c_q, z_q;

    assign op_e = alu_op_e'(op);
    assign c_q  = st_q.status[FC];
    assign z_q  = st_q.status[FZ];

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_a   = opd_a;
        as_b   = opd_b;
        as_sub = 1'b0;
        as_cin = 1'b0;
        unique case (op_e)
            OP_ADC:          as_cin = c_q;
            OP_SUB, OP_CP:   as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = c_q;
            end
            OP_NEG: begin
                as_sub = 1'b1;
                as_a   = '0;
                as_b   = opd_a;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.DW(DW)) addsub_i (
        .a     (as_a),
        .b     (as_b),
        .cin   (as_cin),
        .sub   (as_sub),
        .res   (as_res),
        .c_out (as_c),
        .h_out (as_h),
        .v_out (as_v)
    );

    alu8_bitops bitops_i (
        .op    (op_e),
        .a     (opd_a),
        .b     (opd_b),
        .cin   (c_q),
        .res   (bo_res),
        .c_out (bo_c),
        .h_out (bo_h),
        .v_out (bo_v)
    );

    // result and candidate flags with per-operation mask
    always_comb begin
        logic [DW-1:0] r;
        logic          c, h, v, n, z;
        logic [SRW-1:0] m;

        r = bo_res;
        c = bo_c;
        h = bo_h;
        v = bo_v;
        m = '0;
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                r = as_res;
                c = as_c;
                h = as_h;
                v = as_v;
                m = M_FULL;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: m = M_LOGIC;
            OP_COM, OP_LSR, OP_ASR, OP_ROR:        m = M_NOH;
            OP_LSL, OP_ROL:                        m = M_FULL;
            OP_FSET, OP_FCLR: begin
                r = opd_a;
                m = SRW'(1) << bit_sel;
            end
            default: m = '0;
        endcase

        n = r[DW-1];
        z = (r == '0);
        if (op_e == OP_SBC || op_e == OP_CPC)
            z = z && z_q;

        calc.res  = r;
        calc.mask = m;
        if (op_e == OP_FSET || op_e == OP_FCLR) begin
            calc.flags = {SRW{op_e == OP_FSET}};
        end else begin
            calc.flags     = st_q.status;
            calc.flags[FC] = c;
            calc.flags[FZ] = z;
            calc.flags[FN] = n;
            calc.flags[FV] = v;
            calc.flags[FS] = n ^ v;
            calc.flags[FH] = h;
        end
    end

    alu8_flag_merge #(.SRW(SRW)) merge_i (
        .cur  (st_q.status),
        .upd  (op_valid),
        .mask (calc.mask),
        .newf (calc.flags),
        .nxt  (merged)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign result = calc.res;
    assign status = st_q.status;

endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
    import alu8_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [OPW-1:0]  op,
    input logic [DW-1:0]   opd_a,
    input logic [DW-1:0]   result,
    input logic [SRW-1:0]  status
);
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status));

    a_r13_s_is_n_xor_v: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op < OPW'(OP_SWAP)) |=> (status[FS] == (status[FN] ^ status[FV])));

    a_r7_inc_keeps_c_h: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OPW'(OP_INC)) |=>
            (status[FC] == $past(status[FC]) && status[FH] == $past(status[FH])));

    a_r8_com_sets_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OPW'(OP_COM)) |=> status[FC]);

    a_r11_swap_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OPW'(OP_SWAP)) |=> $stable(status));

    a_r5_sbc_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OPW'(OP_SBC) && !status[FZ]) |=> !status[FZ]);

    a_r3_add_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OPW'(OP_ADD)) |=> (status[FZ] == ($past(result) == '0)));

    a_r11_swap_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPW'(OP_SWAP)) |-> (result == {opd_a[NW-1:0], opd_a[DW-1:NW]}));

endmodule

bind alu8_status_core alu8_status_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op       (op),
    .opd_a    (opd_a),
    .result   (result),
    .status   (status)
);

// File: tb/alu8_status_core_tb_top.sv
`timescale 1ns/1ps
module alu8_status_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] opd_a = '0;
    logic [7:0] opd_b = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_status_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op       (op),
        .opd_a    (opd_a),
        .opd_b    (opd_b),
        .bit_sel  (bit_sel),
        .result   (result),
        .status   (status)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] s, output logic [7:0] r);
        @(negedge clk);
        op_valid = 1'b1;
        op = o;
        opd_a = a;
        opd_b = b;
        bit_sel = s;
        #1 r = result;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    task automatic load_status(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            run_op(v[i] ? 5'd19 : 5'd20, 8'h00, 8'h00, 3'(i), r);
    endtask

    task automatic op_case(input string tag, input logic [4:0] o, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] start,
                           input logic [7:0] exp_r, input logic [7:0] exp_s);
        logic [7:0] r;
        load_status(start);
        run_op(o, a, b, 3'd0, r);
        check8({tag, " result"}, r, exp_r);
        check8({tag, " status"}, status, exp_s);
    endtask

    task automatic t_reset;
        check8("R1 reset status", status, 8'h00);
    endtask

    task automatic t_flag_ops;
        logic [7:0] r;
        load_status(8'hC0);
        check8("R12 load I,T", status, 8'hC0);
        load_status(8'hFF);
        run_op(5'd20, 8'h00, 8'h00, 3'd7, r);
        check8("R12 clear bit7", status, 8'h7F);
        run_op(5'd19, 8'h00, 8'h00, 3'd7, r);
        check8("R12 set bit7", status, 8'hFF);
    endtask

    task automatic t_add;
        op_case("R3 R13 add overflow", 5'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C);
        op_case("R3 adc carry zero",   5'd1, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h23);
    endtask

    task automatic t_sub;
        op_case("R4 sub half borrow", 5'd2, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h20);
        op_case("R4 sub wrap",        5'd2, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h35);
        op_case("R4 R13 cp overflow", 5'd4, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h38);
    endtask

    task automatic t_sbc_z;
        op_case("R5 sbc zero no prior Z", 5'd3, 8'h05, 8'h05, 8'h00, 8'h00, 8'h00);
        op_case("R5 sbc zero prior Z",    5'd3, 8'h05, 8'h05, 8'h02, 8'h00, 8'h02);
        op_case("R5 cpc with carry",      5'd5, 8'h05, 8'h04, 8'h03, 8'h00, 8'h02);
    endtask

    task automatic t_logic;
        op_case("R6 and keeps C H",  5'd6, 8'hF0, 8'h8F, 8'h29, 8'h80, 8'h35);
        op_case("R6 xor zero",       5'd8, 8'h55, 8'h55, 8'h00, 8'h00, 8'h02);
        op_case("R6 or negative",    5'd7, 8'h01, 8'h80, 8'h00, 8'h81, 8'h14);
    endtask

    task automatic t_incdec;
        op_case("R7 inc overflow",   5'd11, 8'h7F, 8'h00, 8'h21, 8'h80, 8'h2D);
        op_case("R7 dec overflow",   5'd12, 8'h80, 8'h00, 8'h00, 8'h7F, 8'h18);
        op_case("R7 dec to zero",    5'd12, 8'h01, 8'h00, 8'h00, 8'h00, 8'h02);
    endtask

    task automatic t_com_neg;
        op_case("R8 com",            5'd9,  8'h00, 8'h00, 8'h28, 8'hFF, 8'h35);
        op_case("R8 neg 0x80",       5'd10, 8'h80, 8'h00, 8'h00, 8'h80, 8'h0D);
        op_case("R8 R4 neg one",     5'd10, 8'h01, 8'h00, 8'h00, 8'hFF, 8'h35);
        op_case("R8 neg zero",       5'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02);
    endtask

    task automatic t_shr;
        op_case("R9 lsr",            5'd13, 8'h81, 8'h00, 8'h00, 8'h40, 8'h19);
        op_case("R9 asr keeps H",    5'd14, 8'h81, 8'h00, 8'h20, 8'hC0, 8'h35);
        op_case("R9 ror carry in",   5'd15, 8'h02, 8'h00, 8'h01, 8'h81, 8'h0C);
    endtask

    task automatic t_shl;
        op_case("R10 lsl half",      5'd16, 8'h88, 8'h00, 8'h00, 8'h10, 8'h39);
        op_case("R10 rol carry in",  5'd17, 8'h40, 8'h00, 8'h01, 8'h81, 8'h0C);
    endtask

    task automatic t_swap;
        op_case("R11 swap all set",  5'd18, 8'hA5, 8'h00, 8'hFF, 8'h5A, 8'hFF);
        op_case("R11 swap all clear", 5'd18, 8'h0F, 8'h00, 8'h00, 8'hF0, 8'h00);
    endtask

    task automatic t_hold;
        load_status(8'h00);
        @(negedge clk);
        op_valid = 1'b0;
        op = 5'd0;
        opd_a = 8'hFF;
        opd_b = 8'h01;
        @(posedge clk);
        #1;
        check8("R2 hold while idle", status, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_flag_ops();
        t_add();
        t_sub();
        t_sbc_z();
        t_logic();
        t_incdec();
        t_com_neg();
        t_shr();
        t_shl();
        t_swap();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule